// File: doc/BRIEF.md
# Exception Return Load Sequencer

This block executes the return-from-exception operation of a 32-bit fixed-width instruction set. When `start` is pulsed, it takes the instruction word, the value of the base register and the current privilege level. It checks that the word is the return-from-exception encoding. It then works out where two consecutive words lie in memory, using one of four layouts. Two flag bits in the instruction word select the layout: the base address is used either before or after an adjustment, and the stack either grows up or grows down.

The block reads the two words one after the other over a plain request/valid memory port, lower address first. The first word becomes the new program counter and the second becomes the new status word. Both are presented with a single `done` pulse. An optional base-register write-back is presented in the same cycle. Privilege gating is applied before any memory access. At the hypervisor level the block raises an undefined-instruction flag. At the user level it does nothing and raises an unpredictable flag.

Top module: `exr_return_seq`

## Requirements
- R1: A word is accepted only when bits 31:25 are 1111100, bit 22 is 0, bit 20 is 1 and bits 15:0 are 0x0A00. Any other word, pulsed on `start`, causes no memory request, no flag, no `done` and no change to `busy`.
- R2: The field layout is: bit 24 is the before flag P, bit 23 is the up flag U, bit 21 is the write-back flag W, and bits 19:16 are the base register index. With base B, the first read address is B when P=0,U=1; B+4 when P=1,U=1; B-4 when P=0,U=0; and B-8 when P=1,U=0.
- R3: The second read is issued only after the first read has completed. Its address is the first address plus 4. `new_pc` carries the first word read and `new_status` carries the second.
- R4: All address sums wrap modulo 2^32. The low two bits of every read address are forced to zero.
- R5: When W=1, `wb_en` is high in the `done` cycle, `wb_reg` carries the index from bits 19:16, and `wb_val` is B+8 (U=1) or B-8 (U=0). The write-back value is not masked. When W=0, `wb_en` stays low.
- R6: At privilege level 2'b10 (hypervisor), an accepted word gives a one-cycle `undef_flag` pulse in the cycle after `start`. No read is made, and there is no `done` and no write-back.
- R7: At privilege level 2'b00 (user), an accepted word gives a one-cycle `unpred_flag` pulse in the cycle after `start`. No read is made, and there is no `done` and no write-back. Levels 2'b01 and 2'b11 perform the return.
- R8: `mem_req` stays high with `mem_addr` stable until `mem_rvalid` is seen. A `mem_rvalid` that arrives in the same cycle as the request completes that read.
- R9: `done` is a single-cycle pulse in the cycle after the second word arrives. While `busy` is high, `start` has no effect. This includes the `done` cycle.
- R10: An active-low synchronous reset returns the block to idle with `busy`, `mem_req`, `done`, `wb_en` and both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Present instruction for execution (honoured only when idle) |
| instr | input | 32 | Instruction word |
| base_val | input | 32 | Current value of the base register |
| priv_level | input | 2 | 00 user, 01 kernel, 10 hypervisor, 11 monitor |
| busy | output | 1 | Sequence in progress |
| mem_req | output | 1 | Read request, held until valid |
| mem_addr | output | 32 | Word-aligned read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 32 | Loaded program counter |
| new_status | output | 32 | Loaded status word |
| wb_en | output | 1 | Base write-back strobe |
| wb_reg | output | 4 | Base register index for write-back |
| wb_val | output | 32 | Adjusted base value |
| undef_flag | output | 1 | Undefined-instruction pulse |
| unpred_flag | output | 1 | Unpredictable (user level) pulse |

## Verification
Two pairs of events can fall in one cycle. A read completion can land in the same cycle its request is first raised, and a new `start` can arrive in the same cycle as the `done` pulse or during the reads. The bench provokes zero-latency responses by raising `mem_rvalid` at the very sample where `mem_req` is first observed, and judges that the next address or the completion follows one cycle later. It also pulses `start` with a hypervisor-level word both mid-sequence and in the `done` cycle, and judges that no flag appears and the block returns to idle with no request.

// File: rtl/exr_pkg.sv
// Package exr_pkg
// Shared types for the exception return load sequencer: the sequencer
// state encoding and the decoded instruction fields.
// Assumes the fixed 32-bit instruction layout, so field widths are fixed here.
package exr_pkg;

    localparam int unsigned INSTR_W = 32;
    localparam int unsigned RIDX_W  = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD0  = 2'd1,
        ST_RD1  = 2'd2,
        ST_FIN  = 2'd3
    } exr_state_t;

    typedef struct packed {
        logic              hit;
        logic              pre;
        logic              up;
        logic              wback;
        logic [RIDX_W-1:0] rn;
    } exr_dec_t;

endpackage

// File: rtl/exr_decode.sv
// Module exr_decode
// Purely combinational recogniser for the return-from-exception word.
// Produces a hit bit and the addressing / write-back fields.
// Assumes the fixed 32-bit encoding; no condition-code handling.
module exr_decode
    import exr_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output exr_dec_t           dec
);

    localparam logic [6:0]  TOP_PATTERN = 7'b1111100;
    localparam logic [15:0] LOW_PATTERN = 16'h0A00;

    // Match the fixed opcode bits and pull out the variable fields.
    always_comb begin
        dec.hit   = (instr[31:25] == TOP_PATTERN) && !instr[22] && instr[20]
                    && (instr[15:0] == LOW_PATTERN);
        dec.pre   = instr[24];
        dec.up    = instr[23];
        dec.wback = instr[21];
        dec.rn    = instr[19:16];
    end

endmodule

// File: rtl/exr_addr_gen.sv
// Module exr_addr_gen
// Combinational address generator: derives the word-aligned first read
// address and the written-back base value from the base and two flags.
// Assumes wrap-around arithmetic in AW bits; WORD_BYTES is a power of two.
module exr_addr_gen #(
    parameter int unsigned AW         = 32,
    parameter int unsigned WORD_BYTES = 4
) (
    input  logic [AW-1:0] base,
    input  logic          pre,
    input  logic          up,
    output logic [AW-1:0] first_addr,
    output logic [AW-1:0] wb_value
);

    localparam int unsigned  PAIR_BYTES = 2 * WORD_BYTES;
    localparam int unsigned  ALIGN_BITS = $clog2(WORD_BYTES);
    localparam logic [AW-1:0] STEP_WORD = AW'(WORD_BYTES);
    localparam logic [AW-1:0] STEP_PAIR = AW'(PAIR_BYTES);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(WORD_BYTES - 1);

    logic [AW-1:0] origin;
    logic [AW-1:0] skewed;

    // Choose origin: base when ascending, base minus a pair when descending.
    always_comb begin
        origin = up ? base : (base - STEP_PAIR);
    end

    // Step one word further when the before-flag equals the up-flag.
    always_comb begin
        skewed     = (pre == up) ? (origin + STEP_WORD) : origin;
        first_addr = skewed & ALIGN_MASK;
    end

    // Adjusted base for optional write-back.
    always_comb begin
        wb_value = up ? (base + STEP_PAIR) : (base - STEP_PAIR);
    end

    // ALIGN_BITS documents the masked width; keep it referenced.
    logic unused_align;
    assign unused_align = (ALIGN_BITS > AW);

endmodule

// File: rtl/exr_seq_fsm.sv
// Module exr_seq_fsm
// Sequencer: gates on privilege, issues two ordered reads with a held
// request, captures the two words and emits a single completion pulse.
// Assumes decode and address inputs are valid whenever start is high.
module exr_seq_fsm
    import exr_pkg::*;
#(
    parameter int unsigned AW         = 32,
    parameter int unsigned DW         = 32,
    parameter int unsigned PRIVW      = 2,
    parameter int unsigned WORD_BYTES = 4,
    parameter logic [PRIVW-1:0] PRIV_USER = 2'b00,
    parameter logic [PRIVW-1:0] PRIV_HYP  = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  exr_dec_t          dec,
    input  logic [PRIVW-1:0]  priv,
    input  logic [AW-1:0]     first_addr,
    input  logic [AW-1:0]     wb_value,
    input  logic              mem_rvalid,
    input  logic [DW-1:0]     mem_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    output logic              done,
    output logic [DW-1:0]     new_pc,
    output logic [DW-1:0]     new_status,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_reg,
    output logic [AW-1:0]     wb_val,
    output logic              undef_flag,
    output logic              unpred_flag
);

    localparam logic [AW-1:0] NEXT_WORD = AW'(WORD_BYTES);

    exr_state_t        state_q, state_d;
    logic [AW-1:0]     addr_q;
    logic [AW-1:0]     wbv_q;
    logic [RIDX_W-1:0] rn_q;
    logic              wbk_q;
    logic [DW-1:0]     pc_q;
    logic [DW-1:0]     st_q;
    logic              undef_q;
    logic              unpred_q;
    logic              accept;
    logic              go_hyp;
    logic              go_user;

    // Classify a start seen while idle.
    always_comb begin
        accept  = start && dec.hit && (state_q == ST_IDLE);
        go_hyp  = accept && (priv == PRIV_HYP);
        go_user = accept && (priv == PRIV_USER);
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && !go_hyp && !go_user) state_d = ST_RD0;
            ST_RD0:  if (mem_rvalid) state_d = ST_RD1;
            ST_RD1:  if (mem_rvalid) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Address and write-back context: latched at acceptance, stepped after read 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            wbv_q  <= '0;
            rn_q   <= '0;
            wbk_q  <= 1'b0;
        end else if (state_q == ST_IDLE && state_d == ST_RD0) begin
            addr_q <= first_addr;
            wbv_q  <= wb_value;
            rn_q   <= dec.rn;
            wbk_q  <= dec.wback;
        end else if (state_q == ST_RD0 && mem_rvalid) begin
            addr_q <= addr_q + NEXT_WORD;
        end
    end

    // Capture of the two loaded words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            st_q <= '0;
        end else begin
            if (state_q == ST_RD0 && mem_rvalid) pc_q <= mem_rdata;
            if (state_q == ST_RD1 && mem_rvalid) st_q <= mem_rdata;
        end
    end

    // One-cycle privilege fault pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            undef_q  <= 1'b0;
            unpred_q <= 1'b0;
        end else begin
            undef_q  <= go_hyp;
            unpred_q <= go_user;
        end
    end

    // Output drive.
    always_comb begin
        busy        = (state_q != ST_IDLE);
        mem_req     = (state_q == ST_RD0) || (state_q == ST_RD1);
        mem_addr    = addr_q;
        done        = (state_q == ST_FIN);
        new_pc      = pc_q;
        new_status  = st_q;
        wb_en       = done && wbk_q;
        wb_reg      = rn_q;
        wb_val      = wbv_q;
        undef_flag  = undef_q;
        unpred_flag = unpred_q;
    end

endmodule

// File: rtl/exr_return_seq.sv
// Module exr_return_seq
// Top of the exception return load sequencer: decode, address generation
// and the load sequencer. The caller owns the register file and the PC.
// Assumes start is a single-cycle pulse that is honoured only while idle.
module exr_return_seq
    import exr_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned DW    = 32,
    parameter int unsigned PRIVW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      instr,
    input  logic [AW-1:0]    base_val,
    input  logic [PRIVW-1:0] priv_level,
    output logic             busy,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_rvalid,
    input  logic [DW-1:0]    mem_rdata,
    output logic             done,
    output logic [DW-1:0]    new_pc,
    output logic [DW-1:0]    new_status,
    output logic             wb_en,
    output logic [3:0]       wb_reg,
    output logic [AW-1:0]    wb_val,
    output logic             undef_flag,
    output logic             unpred_flag
);

    localparam int unsigned WORD_BYTES = DW / 8;

    exr_dec_t      dec;
    logic [AW-1:0] first_addr;
    logic [AW-1:0] wb_value;

    exr_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    exr_addr_gen #(
        .AW         (AW),
        .WORD_BYTES (WORD_BYTES)
    ) u_agen (
        .base       (base_val),
        .pre        (dec.pre),
        .up         (dec.up),
        .first_addr (first_addr),
        .wb_value   (wb_value)
    );

    exr_seq_fsm #(
        .AW         (AW),
        .DW         (DW),
        .PRIVW      (PRIVW),
        .WORD_BYTES (WORD_BYTES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .dec         (dec),
        .priv        (priv_level),
        .first_addr  (first_addr),
        .wb_value    (wb_value),
        .mem_rvalid  (mem_rvalid),
        .mem_rdata   (mem_rdata),
        .busy        (busy),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .done        (done),
        .new_pc      (new_pc),
        .new_status  (new_status),
        .wb_en       (wb_en),
        .wb_reg      (wb_reg),
        .wb_val      (wb_val),
        .undef_flag  (undef_flag),
        .unpred_flag (unpred_flag)
    );

endmodule

// File: rtl/exr_return_seq_chk.sv
// Module exr_return_seq_chk
// Property checker for exr_return_seq, attached by bind below.
// Observes only top-level ports.
module exr_return_seq_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rvalid,
    input logic          done,
    input logic          wb_en,
    input logic          undef_flag,
    input logic          unpred_flag
);

    // R8: request and address held until valid
    a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R3: a read that follows a completed read is one word higher
    a_r3_second_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid) |=> (!mem_req || (mem_addr == $past(mem_addr) + AW'(4))));

    // R4: every requested address is word aligned
    a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a start while busy raises no flag
    a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (!undef_flag && !unpred_flag));

    // R5: write-back only alongside completion
    a_r5_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    // R6: undefined pulse comes with no activity
    a_r6_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        undef_flag |-> (!busy && !mem_req && !done && !unpred_flag));

    // R7: unpredictable pulse comes with no activity
    a_r7_unpred_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        unpred_flag |-> (!busy && !mem_req && !done));

    // R10: a reset cycle leaves the block idle
    a_r10_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy && !mem_req && !done && !undef_flag && !unpred_flag));

endmodule

bind exr_return_seq exr_return_seq_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_rvalid  (mem_rvalid),
    .done        (done),
    .wb_en       (wb_en),
    .undef_flag  (undef_flag),
    .unpred_flag (unpred_flag)
);

// File: tb/exr_return_seq_test.sv
// Bench for exr_return_seq: a vector table walked by one loop, then directed
// tests for same-cycle events and reset. Inputs change on the falling edge.
module exr_return_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] base_val = '0;
    logic [1:0]  priv_level = 2'b01;
    logic        busy, mem_req, done, wb_en, undef_flag, unpred_flag;
    logic [31:0] mem_addr, new_pc, new_status, wb_val;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  wb_reg;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    exr_return_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .base_val(base_val), .priv_level(priv_level), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .new_pc(new_pc),
        .new_status(new_status), .wb_en(wb_en), .wb_reg(wb_reg),
        .wb_val(wb_val), .undef_flag(undef_flag), .unpred_flag(unpred_flag)
    );

    // kind: 0 perform, 1 hypervisor, 2 user, 3 not recognised
    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] base;
        logic [1:0]  lvl;
        logic [1:0]  lat;
        logic [1:0]  kind;
        logic [31:0] a0;
        logic        wb;
        logic [31:0] wbv;
        logic [3:0]  rn;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'hF8B10A00, 32'h00001000, 2'b01, 2'd1, 2'd0, 32'h00001000, 1'b1, 32'h00001008, 4'd1},
        '{32'hF9920A00, 32'h00001000, 2'b01, 2'd0, 2'd0, 32'h00001004, 1'b0, 32'h00000000, 4'd2},
        '{32'hF8330A00, 32'h00001000, 2'b11, 2'd2, 2'd0, 32'h00000FFC, 1'b1, 32'h00000FF8, 4'd3},
        '{32'hF93D0A00, 32'h00001000, 2'b01, 2'd3, 2'd0, 32'h00000FF8, 1'b1, 32'h00000FF8, 4'd13},
        '{32'hF9300A00, 32'h00000004, 2'b01, 2'd0, 2'd0, 32'hFFFFFFFC, 1'b1, 32'hFFFFFFFC, 4'd0},
        '{32'hF9BE0A00, 32'hFFFFFFFC, 2'b11, 2'd1, 2'd0, 32'h00000000, 1'b1, 32'h00000004, 4'd14},
        '{32'hF8B50A00, 32'h00001003, 2'b01, 2'd0, 2'd0, 32'h00001000, 1'b1, 32'h0000100B, 4'd5},
        '{32'hF8170A00, 32'h00002002, 2'b01, 2'd2, 2'd0, 32'h00001FFC, 1'b0, 32'h00000000, 4'd7},
        '{32'hF8910A00, 32'h00001000, 2'b10, 2'd0, 2'd1, 32'h0,        1'b0, 32'h0,        4'd1},
        '{32'hF9340A00, 32'h00001000, 2'b00, 2'd0, 2'd2, 32'h0,        1'b0, 32'h0,        4'd4},
        '{32'hF8D10A00, 32'h00001000, 2'b01, 2'd0, 2'd3, 32'h0,        1'b0, 32'h0,        4'd1},
        '{32'hF8910A01, 32'h00001000, 2'b01, 2'd0, 2'd3, 32'h0,        1'b0, 32'h0,        4'd1},
        '{32'hF9920A00, 32'h00001000, 2'b10, 2'd0, 2'd1, 32'h0,        1'b0, 32'h0,        4'd2}
    };

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h5A3C0F96;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Serve one read: wait for the request, check its address, answer after lat cycles.
    task automatic serve(input logic [31:0] exp_addr, input int lat, input string req);
        int n = 0;
        while (!mem_req && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(mem_req == 1'b1, "R3", "request seen", 32'(mem_req), 32'd1);
        chk(mem_addr == exp_addr, req, "read address", mem_addr, exp_addr);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk(mem_req && mem_addr == exp_addr, "R8", "request held", mem_addr, exp_addr);
        end
        mem_rvalid = 1'b1;
        mem_rdata  = mem_word(exp_addr);
        @(negedge clk);
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
    endtask

    task automatic pulse_start(input logic [31:0] ins, input logic [31:0] b, input logic [1:0] lvl);
        instr = ins; base_val = b; priv_level = lvl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic check_quiet(input string req);
        chk(!busy && !mem_req && !done && !wb_en, req, "idle, no activity",
            {28'd0, busy, mem_req, done, wb_en}, 32'd0);
    endtask

    task automatic summary_and_end;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run is counted as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            summary_and_end();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!busy && !mem_req && !done && !wb_en && !undef_flag && !unpred_flag,
            "R10", "reset outputs", {26'd0, busy, mem_req, done, wb_en, undef_flag, unpred_flag}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            vec_t t = VECS[v];
            pulse_start(t.ins, t.base, t.lvl);
            case (t.kind)
                2'd0: begin
                    serve(t.a0, int'(t.lat), "R2");
                    serve(t.a0 + 32'd4, int'(t.lat), "R4");
                    chk(done == 1'b1, "R9", "done pulse", 32'(done), 32'd1);
                    chk(new_pc == mem_word(t.a0), "R3", "new pc", new_pc, mem_word(t.a0));
                    chk(new_status == mem_word(t.a0 + 32'd4), "R3", "new status",
                        new_status, mem_word(t.a0 + 32'd4));
                    chk(wb_en == t.wb, "R5", "write-back strobe", 32'(wb_en), 32'(t.wb));
                    if (t.wb) begin
                        chk(wb_val == t.wbv, "R5", "write-back value", wb_val, t.wbv);
                        chk(wb_reg == t.rn, "R5", "write-back index", 32'(wb_reg), 32'(t.rn));
                    end
                    @(negedge clk);
                    chk(!done && !busy && !mem_req, "R9", "done single cycle",
                        {29'd0, done, busy, mem_req}, 32'd0);
                end
                2'd1: begin
                    chk(undef_flag && !unpred_flag && !mem_req && !busy, "R6", "undefined pulse",
                        {29'd0, undef_flag, unpred_flag, mem_req}, 32'd4);
                    @(negedge clk);
                    chk(!undef_flag, "R6", "undefined pulse ends", 32'(undef_flag), 32'd0);
                    check_quiet("R6");
                end
                2'd2: begin
                    chk(unpred_flag && !undef_flag && !mem_req && !busy, "R7", "unpredictable pulse",
                        {29'd0, unpred_flag, undef_flag, mem_req}, 32'd4);
                    @(negedge clk);
                    chk(!unpred_flag, "R7", "unpredictable pulse ends", 32'(unpred_flag), 32'd0);
                    check_quiet("R7");
                end
                default: begin
                    chk(!undef_flag && !unpred_flag, "R1", "no flag on foreign word",
                        {30'd0, undef_flag, unpred_flag}, 32'd0);
                    check_quiet("R1");
                    @(negedge clk);
                    check_quiet("R1");
                end
            endcase
            @(negedge clk);
        end

        // R9: start during the reads and in the done cycle is ignored
        pulse_start(32'hF8B10A00, 32'h00003000, 2'b01);
        instr = 32'hF8910A00; priv_level = 2'b10; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!undef_flag, "R9", "start while reading ignored", 32'(undef_flag), 32'd0);
        serve(32'h00003000, 0, "R2");
        serve(32'h00003004, 0, "R8");
        chk(done && wb_en, "R9", "done with write-back", {30'd0, done, wb_en}, 32'd3);
        instr = 32'hF8910A00; priv_level = 2'b10; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!undef_flag && !busy && !mem_req, "R9", "start in done cycle ignored",
            {29'd0, undef_flag, busy, mem_req}, 32'd0);
        @(negedge clk);

        // R10: reset in the middle of a sequence
        pulse_start(32'hF8B10A00, 32'h00004000, 2'b01);
        chk(mem_req == 1'b1, "R10", "request before reset", 32'(mem_req), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_req && !done && !wb_en, "R10", "reset mid-sequence",
            {28'd0, busy, mem_req, done, wb_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R10");

        summary_and_end();
    end

endmodule